// File: doc/BRIEF.md
# Serial Peripheral Interrupt Aggregator

This block gathers the interrupt sources of a serial-port engine into one 32-bit status register. It weighs that register against a per-bit enable register and drives a single level interrupt line, which a global enable bit gates. Software reaches the three registers through a simple word-addressed strobe interface. A write to the status register flips every bit that is written as 1. To acknowledge an interrupt, software writes back the bits it has just read.

Four event inputs are single-cycle pulses: receive overrun, transmit empty, transmit underrun and transmit half-empty. Each pulse latches its status bit. Two inputs are live levels taken from the receive FIFO: not-empty and full. These levels are ORed into the status register on every clock, so software cannot clear those bits while the condition lasts. The interrupt line is registered and follows the register state one clock later.

Top module: `serial_irq_aggregator`

## Requirements
- R1: After synchronous reset the status, enable and global-enable registers all read 0 and `irq` is low.
- R2: Word address 7 selects global enable, 8 selects status and 10 selects enable. A read of any other address returns 0, and a write to any other address changes no register.
- R3: A write to the status register replaces its contents with the old contents XOR the written data, so a 1 both clears set bits and sets clear ones.
- R4: A pulse on an event input sets its status bit: transmit-empty sets bit 2, transmit-underrun bit 3, receive-overrun bit 5 and transmit-half-empty bit 6. The bit then stays set after the pulse ends.
- R5: While `lvl_rx_full` is high, status bit 4 is set on every clock. While `lvl_rx_not_empty` is high, status bit 8 is set on every clock. A toggle write cannot clear either bit while its level is high.
- R6: When an event and a status write that flips the same bit fall in the same cycle, the bit ends up set.
- R7: The enable register takes the full 32-bit written value and reads it back unchanged.
- R8: The global-enable register keeps only bit 31 of the written data. Its other bits always read 0.
- R9: `irq` equals (any bit of status AND enable is set) AND global-enable bit 31, sampled one clock earlier. It changes exactly one clock after the registers change.
- R10: `reg_rdata` is 0 whenever `reg_rd` is low, and a read changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (5) | Word address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, 0 when no read is active |
| ev_rx_overrun | input | 1 | Receive overrun event pulse |
| ev_tx_empty | input | 1 | Transmit empty event pulse |
| ev_tx_underrun | input | 1 | Transmit underrun event pulse |
| ev_tx_half_empty | input | 1 | Transmit half-empty event pulse |
| lvl_rx_not_empty | input | 1 | Live receive FIFO not-empty level |
| lvl_rx_full | input | 1 | Live receive FIFO full level |
| irq | output | 1 | Registered interrupt line |

## Verification
Directed cases toggle the same status bit twice. This shows XOR behaviour apart from plain write-one-to-clear, because a second write of 1 sets the bit again instead of leaving it clear. A pulse placed in the same cycle as a toggle of its own bit shows whether the event or the write wins. Holding a live receive level high while software toggles its bit shows the difference between a refreshed bit and a latched one. Random cycles then mix pulses, level changes and writes to mapped and unmapped addresses, while `irq` is compared every clock. This catches errors in the gating terms and in the one-clock latency.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;

    localparam int unsigned REG_W = 32;

    // status bit positions (software decodes these)
    localparam int unsigned BIT_TX_EMPTY     = 2;
    localparam int unsigned BIT_TX_UNDERRUN  = 3;
    localparam int unsigned BIT_RX_FULL      = 4;
    localparam int unsigned BIT_RX_OVERRUN   = 5;
    localparam int unsigned BIT_TX_HALF      = 6;
    localparam int unsigned BIT_RX_NOT_EMPTY = 8;
    localparam int unsigned BIT_GLOBAL_EN    = REG_W - 1;

    typedef struct packed {
        logic rx_overrun;
        logic tx_empty;
        logic tx_underrun;
        logic tx_half;
    } irq_pulse_t;

    typedef struct packed {
        logic rx_not_empty;
        logic rx_full;
    } rx_level_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_GLOBAL,
        SEL_STATUS,
        SEL_ENABLE
    } reg_sel_e;

    function automatic logic [REG_W-1:0] build_set_mask(irq_pulse_t p, rx_level_t l);
        logic [REG_W-1:0] m;
        m = '0;
        m[BIT_TX_EMPTY]     = p.tx_empty;
        m[BIT_TX_UNDERRUN]  = p.tx_underrun;
        m[BIT_RX_OVERRUN]   = p.rx_overrun;
        m[BIT_TX_HALF]      = p.tx_half;
        m[BIT_RX_FULL]      = l.rx_full;
        m[BIT_RX_NOT_EMPTY] = l.rx_not_empty;
        return m;
    endfunction

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import serial_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tgl_en,
    input  logic [REG_W-1:0] tgl_val,
    input  logic [REG_W-1:0] set_mask,
    output logic [REG_W-1:0] status
);

    logic [REG_W-1:0] flipped;

    always_comb begin
        flipped = tgl_en ? (status ^ tgl_val) : status;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= flipped | set_mask;
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((status & $past(set_mask)) == $past(set_mask)));

    assert_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (tgl_en && set_mask == '0) |=> ((status ^ $past(status)) == $past(tgl_val)));

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import serial_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_enable,
    input  logic             wr_global,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] enable,
    output logic             global_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable    <= '0;
            global_en <= 1'b0;
        end else begin
            if (wr_enable) enable    <= wdata;
            if (wr_global) global_en <= wdata[BIT_GLOBAL_EN];
        end
    end

    assert_enable_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_enable |=> $stable(enable));

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
    import serial_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] status,
    input  logic [REG_W-1:0] enable,
    input  logic             global_en,
    output logic             irq
);

    logic pending;

    always_comb begin
        pending = (|(status & enable)) && global_en;
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= pending;
    end

    assert_gated_off_R9: assert property (@(posedge clk) disable iff (rst)
        !global_en |=> !irq);

    assert_nothing_pending_R9: assert property (@(posedge clk) disable iff (rst)
        ((status & enable) == '0) |=> !irq);

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

// File: rtl/serial_irq_aggregator.sv
module serial_irq_aggregator
    import serial_irq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned GLOBAL_WORD = 7,
    parameter int unsigned STATUS_WORD = 8,
    parameter int unsigned ENABLE_WORD = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ev_rx_overrun,
    input  logic              ev_tx_empty,
    input  logic              ev_tx_underrun,
    input  logic              ev_tx_half_empty,
    input  logic              lvl_rx_not_empty,
    input  logic              lvl_rx_full,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(GLOBAL_WORD);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_WORD);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(ENABLE_WORD);

    reg_sel_e         sel;
    irq_pulse_t       pulses;
    rx_level_t        levels;
    logic [REG_W-1:0] set_mask;
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] enable;
    logic             global_en;

    always_comb begin
        case (reg_addr)
            A_GLOBAL: sel = SEL_GLOBAL;
            A_STATUS: sel = SEL_STATUS;
            A_ENABLE: sel = SEL_ENABLE;
            default:  sel = SEL_NONE;
        endcase
    end

    always_comb begin
        pulses.rx_overrun   = ev_rx_overrun;
        pulses.tx_empty     = ev_tx_empty;
        pulses.tx_underrun  = ev_tx_underrun;
        pulses.tx_half      = ev_tx_half_empty;
        levels.rx_not_empty = lvl_rx_not_empty;
        levels.rx_full      = lvl_rx_full;
        set_mask            = build_set_mask(pulses, levels);
    end

    irq_status_reg u_status (
        .clk      (clk),
        .rst      (rst),
        .tgl_en   (reg_wr && sel == SEL_STATUS),
        .tgl_val  (reg_wdata),
        .set_mask (set_mask),
        .status   (status)
    );

    irq_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_enable (reg_wr && sel == SEL_ENABLE),
        .wr_global (reg_wr && sel == SEL_GLOBAL),
        .wdata     (reg_wdata),
        .enable    (enable),
        .global_en (global_en)
    );

    irq_out_gen u_out (
        .clk       (clk),
        .rst       (rst),
        .status    (status),
        .enable    (enable),
        .global_en (global_en),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (sel)
                SEL_GLOBAL: reg_rdata[BIT_GLOBAL_EN] = global_en;
                SEL_STATUS: reg_rdata = status;
                SEL_ENABLE: reg_rdata = enable;
                default:    reg_rdata = '0;
            endcase
        end
    end

    always_comb begin
        if (!reg_rd) assert_idle_rdata_R10: assert (reg_rdata == '0);
    end

    assert_live_ne_R5: assert property (@(posedge clk) disable iff (rst)
        lvl_rx_not_empty |=> status[BIT_RX_NOT_EMPTY]);

    assert_live_full_R5: assert property (@(posedge clk) disable iff (rst)
        lvl_rx_full |=> status[BIT_RX_FULL]);

    assert_unmapped_wr_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel == SEL_NONE) |=> ($stable(enable) && $stable(global_en)));

endmodule

// File: tb/tb_serial_irq_aggregator.sv
module tb_serial_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_rx_overrun = 1'b0;
    logic        ev_tx_empty = 1'b0;
    logic        ev_tx_underrun = 1'b0;
    logic        ev_tx_half_empty = 1'b0;
    logic        lvl_rx_not_empty = 1'b0;
    logic        lvl_rx_full = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_st, m_en;
    logic        m_gie, m_irq;

    always #10 clk = ~clk;

    serial_irq_aggregator dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_rx_overrun(ev_rx_overrun), .ev_tx_empty(ev_tx_empty),
        .ev_tx_underrun(ev_tx_underrun), .ev_tx_half_empty(ev_tx_half_empty),
        .lvl_rx_not_empty(lvl_rx_not_empty), .lvl_rx_full(lvl_rx_full), .irq(irq)
    );

    function automatic logic [31:0] exp_set(logic [3:0] p, logic ne, logic fu);
        logic [31:0] m;
        m = '0;
        m[5] = p[3]; m[2] = p[2]; m[3] = p[1]; m[6] = p[0];
        m[4] = fu;   m[8] = ne;
        return m;
    endfunction

    function automatic logic [31:0] exp_read(logic [4:0] a);
        case (a)
            5'd7:    return {m_gie, 31'b0};
            5'd8:    return m_st;
            5'd10:   return m_en;
            default: return 32'b0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model, check irq at the next negedge
    task automatic cycle(logic wr, logic [4:0] a, logic [31:0] wd, logic [3:0] p);
        logic [31:0] setm;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        {ev_rx_overrun, ev_tx_empty, ev_tx_underrun, ev_tx_half_empty} = p;
        setm  = exp_set(p, lvl_rx_not_empty, lvl_rx_full);
        m_irq = (|(m_st & m_en)) && m_gie;
        if (wr && a == 5'd8)  m_st = m_st ^ wd;
        m_st = m_st | setm;
        if (wr && a == 5'd10) m_en = wd;
        if (wr && a == 5'd7)  m_gie = wd[31];
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        {ev_rx_overrun, ev_tx_empty, ev_tx_underrun, ev_tx_half_empty} = 4'b0;
        check("R9 irq", {31'b0, irq}, {31'b0, m_irq});
    endtask

    task automatic rd(string req, logic [4:0] a);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        check(req, reg_rdata, exp_read(a));
        reg_rd = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        m_st = '0; m_en = '0; m_gie = 1'b0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd("R1 global", 5'd7); rd("R1 status", 5'd8); rd("R1 enable", 5'd10);
        check("R1 irq", {31'b0, irq}, 32'b0);

        // R10 idle read data
        reg_addr = 5'd10; #1;
        check("R10 idle rdata", reg_rdata, 32'b0);

        // R7 enable readback
        cycle(1'b1, 5'd10, 32'hA5A5_0F0F, 4'b0);
        rd("R7 enable", 5'd10);
        // R8 only bit 31 kept
        cycle(1'b1, 5'd7, 32'hFFFF_FFFF, 4'b0);
        rd("R8 global", 5'd7);
        // R2 unmapped write ignored, unmapped read 0
        cycle(1'b1, 5'd3, 32'hFFFF_FFFF, 4'b0);
        rd("R2 unmapped", 5'd3);
        rd("R2 enable kept", 5'd10);
        rd("R2 global kept", 5'd7);
        // R3 toggle: set then clear bit 0, bit 1 stays
        cycle(1'b1, 5'd8, 32'h0000_0003, 4'b0);
        rd("R3 toggle on", 5'd8);
        cycle(1'b1, 5'd8, 32'h0000_0001, 4'b0);
        rd("R3 toggle off", 5'd8);
        // R4 each event pulse
        cycle(1'b0, 5'd0, 32'h0, 4'b0100); rd("R4 tx empty", 5'd8);
        cycle(1'b0, 5'd0, 32'h0, 4'b0010); rd("R4 underrun", 5'd8);
        cycle(1'b0, 5'd0, 32'h0, 4'b1000); rd("R4 overrun", 5'd8);
        cycle(1'b0, 5'd0, 32'h0, 4'b0001); rd("R4 half", 5'd8);
        cycle(1'b0, 5'd0, 32'h0, 4'b0000); rd("R4 sticky", 5'd8);
        // R6 toggle and pulse on bit 3 in same cycle
        cycle(1'b1, 5'd8, 32'h0000_0008, 4'b0010);
        rd("R6 set wins", 5'd8);
        // R5 live level resists toggle
        lvl_rx_not_empty = 1'b1; lvl_rx_full = 1'b1;
        cycle(1'b0, 5'd0, 32'h0, 4'b0);
        cycle(1'b1, 5'd8, 32'h0000_0110, 4'b0);
        rd("R5 live held", 5'd8);
        lvl_rx_not_empty = 1'b0; lvl_rx_full = 1'b0;
        cycle(1'b1, 5'd8, 32'h0000_0110, 4'b0);
        rd("R5 cleared after level drops", 5'd8);
        // clear status fully
        cycle(1'b1, 5'd8, m_st, 4'b0);
        rd("R3 all clear", 5'd8);
        // R9 latency: enable write, irq one clock later
        cycle(1'b1, 5'd10, 32'h0, 4'b0);
        cycle(1'b1, 5'd8, 32'h0000_0004, 4'b0);
        cycle(1'b1, 5'd10, 32'h0000_0004, 4'b0);
        check("R9 not yet", {31'b0, irq}, 32'b0);
        cycle(1'b0, 5'd0, 32'h0, 4'b0);
        check("R9 asserted", {31'b0, irq}, 32'b1);
        cycle(1'b1, 5'd7, 32'h7FFF_FFFF, 4'b0);
        cycle(1'b0, 5'd0, 32'h0, 4'b0);
        check("R9 gated off", {31'b0, irq}, 32'b0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  p;
            logic [4:0]  a;
            logic        w;
            logic [31:0] d;
            p = 4'b0;
            for (int k = 0; k < 4; k++) p[k] = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 15) == 0) lvl_rx_not_empty = ~lvl_rx_not_empty;
            if ($urandom_range(0, 31) == 0) lvl_rx_full = ~lvl_rx_full;
            case ($urandom_range(0, 3))
                0: a = 5'd7;
                1: a = 5'd8;
                2: a = 5'd10;
                default: a = 5'($urandom_range(0, 31));
            endcase
            w = ($urandom_range(0, 3) == 0);
            d = $urandom;
            if (a == 5'd8 && $urandom_range(0, 1) == 0) d = m_st;
            if (a == 5'd10) d = d & 32'h0000_017C;
            cycle(w, a, d, p);
            if (i % 8 == 0) begin
                rd("R3 R4 R5 random status", 5'd8);
                rd("R7 random enable", 5'd10);
                rd("R8 random global", 5'd7);
                rd("R2 random addr", 5'($urandom_range(0, 31)));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule